// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after instruction fetch. It receives a six-byte window taken from memory at the current program counter, together with a flag that says whether that fetch address was legal. In a single pass it splits the first instruction in the window into its fields:

- the operation code and the function code;
- the two register identifiers;
- a 32-bit constant, assembled from little-endian bytes.

It also works out how many bytes the instruction occupies, the address of the next sequential instruction, and a status code that tells the pipeline whether to carry on.

The first byte alone decides the format. Instructions are 1, 2, 5 or 6 bytes long. The constant begins at byte 1 when no register byte is present, and at byte 2 when one is. Bytes past the decoded length play no part in the result. The decode logic is combinational. The parameter `REG_OUT` places one register stage at the output, which makes every result due one clock edge after its inputs.

Top module: `instr_fetch_decoder`

## Requirements
- R1: `opcode_o` equals bits [7:4] of byte 0 and `fncode_o` equals bits [3:0] of byte 0, whatever the status. Byte k of the window is `win_i[8k+7:8k]`.
- R2: `len_o` is 1 for operation codes 0x0, 0x1 and 0x9. It is 2 for 0x2, 0x6, 0xA and 0xB. It is 5 for 0x7 and 0x8. It is 6 for 0x3, 0x4 and 0x5.
- R3: For 2-byte and 6-byte instructions, `rsrc_o` is byte 1 bits [7:4] and `rdst_o` is byte 1 bits [3:0]. For every other instruction both outputs are 0xF, the "no register" code.
- R4: For 5-byte instructions, `imm_o` is bytes 1 to 4 read little-endian. For 6-byte instructions it is bytes 2 to 5 read little-endian. Otherwise it is 0. Bytes beyond the length never affect any output.
- R5: `npc_o` equals `pc_i + len_o` modulo 2^32.
- R6: A legal, fetchable instruction gives status 1 (normal). Byte 0 equal to 0x00 gives status 2 (halt) with length 1.
- R7: Status 4 (invalid) is produced in any of these cases:
  - the operation code is above 0xB;
  - the function code is nonzero on any operation code other than 0x6 and 0x7;
  - the function code is above 3 on 0x6;
  - the function code is above 6 on 0x7.
- R8: When `fetch_ok_i` is low, status is 3 (bad address). This takes priority over the halt and invalid statuses.
- R9: Under status 3 or 4, `len_o` is 0, `npc_o` equals `pc_i`, both register outputs are 0xF and `imm_o` is 0.
- R10: With `REG_OUT`=1, outputs hold their reset values while `rst_n` is low: status 1, length 0, next address 0, registers 0xF, constant 0, codes 0. Each result appears on the first rising edge after its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Address of byte 0 of the window |
| win_i | input | 48 | Six fetched bytes, byte 0 in bits [7:0] |
| fetch_ok_i | input | 1 | High when the fetch address is legal |
| opcode_o | output | 4 | Operation code |
| fncode_o | output | 4 | Function code |
| rsrc_o | output | 4 | First register identifier |
| rdst_o | output | 4 | Second register identifier |
| imm_o | output | 32 | Assembled constant |
| len_o | output | 3 | Instruction length in bytes |
| npc_o | output | 32 | Next sequential address |
| status_o | output | 3 | 1 normal, 2 halt, 3 bad address, 4 invalid |

## Verification
Every output depends only on the window, the address and the valid flag applied before the most recent rising edge. With the default output stage, each result is therefore due exactly one edge after its stimulus. The bench drives each stimulus on a falling edge, waits for one rising edge, and samples all outputs on the following falling edge. The bound checker delays its own copies of the inputs by the same single stage, so that it compares each output with the inputs that produced it. It skips the first cycle after reset, when the stage still holds reset values.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int WORD_W   = 32;
    localparam int NIB_W    = 4;
    localparam int BYTE_W   = 8;
    localparam int WIN_B    = 6;
    localparam int WIN_W    = WIN_B * BYTE_W;
    localparam int LEN_W    = 3;
    localparam int CBYTES   = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    localparam logic [NIB_W-1:0] OP_HALT = 4'h0;
    localparam logic [NIB_W-1:0] OP_NOP  = 4'h1;
    localparam logic [NIB_W-1:0] OP_RR   = 4'h2;
    localparam logic [NIB_W-1:0] OP_IR   = 4'h3;
    localparam logic [NIB_W-1:0] OP_RM   = 4'h4;
    localparam logic [NIB_W-1:0] OP_MR   = 4'h5;
    localparam logic [NIB_W-1:0] OP_ALU  = 4'h6;
    localparam logic [NIB_W-1:0] OP_JMP  = 4'h7;
    localparam logic [NIB_W-1:0] OP_CALL = 4'h8;
    localparam logic [NIB_W-1:0] OP_RET  = 4'h9;
    localparam logic [NIB_W-1:0] OP_PUSH = 4'hA;
    localparam logic [NIB_W-1:0] OP_POP  = 4'hB;

    localparam logic [NIB_W-1:0] REG_NONE   = 4'hF;
    localparam logic [NIB_W-1:0] ALU_FN_MAX = 4'd3;
    localparam logic [NIB_W-1:0] JMP_FN_MAX = 4'd6;

    // where the constant starts in the window
    typedef enum logic [1:0] {
        CST_NONE  = 2'd0,
        CST_BYTE1 = 2'd1,
        CST_BYTE2 = 2'd2
    } cst_pos_e;

    typedef struct packed {
        logic [NIB_W-1:0]  opcode;
        logic [NIB_W-1:0]  fncode;
        logic [NIB_W-1:0]  rsrc;
        logic [NIB_W-1:0]  rdst;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] npc;
        stat_e             status;
    } dec_t;

    localparam dec_t DEC_RESET = '{
        opcode: '0,
        fncode: '0,
        rsrc:   REG_NONE,
        rdst:   REG_NONE,
        imm:    '0,
        len:    '0,
        npc:    '0,
        status: ST_AOK
    };

endpackage

// File: rtl/ifd_format.sv
// Classifies byte 0: length, register-byte presence, constant position, legality.
module ifd_format
    import ifd_pkg::*;
(
    input  logic [NIB_W-1:0] opcode_i,
    input  logic [NIB_W-1:0] fncode_i,
    output logic [LEN_W-1:0] len_o,
    output logic             has_reg_o,
    output cst_pos_e         cst_pos_o,
    output logic             legal_o
);

    logic fn_zero;
    assign fn_zero = (fncode_i == '0);

    always_comb begin
        len_o     = LEN_W'(1);
        has_reg_o = 1'b0;
        cst_pos_o = CST_NONE;
        legal_o   = 1'b0;
        case (opcode_i)
            OP_HALT, OP_NOP, OP_RET: begin
                len_o   = LEN_W'(1);
                legal_o = fn_zero;
            end
            OP_RR, OP_PUSH, OP_POP: begin
                len_o     = LEN_W'(2);
                has_reg_o = 1'b1;
                legal_o   = fn_zero;
            end
            OP_ALU: begin
                len_o     = LEN_W'(2);
                has_reg_o = 1'b1;
                legal_o   = (fncode_i <= ALU_FN_MAX);
            end
            OP_JMP: begin
                len_o     = LEN_W'(5);
                cst_pos_o = CST_BYTE1;
                legal_o   = (fncode_i <= JMP_FN_MAX);
            end
            OP_CALL: begin
                len_o     = LEN_W'(5);
                cst_pos_o = CST_BYTE1;
                legal_o   = fn_zero;
            end
            OP_IR, OP_RM, OP_MR: begin
                len_o     = LEN_W'(6);
                has_reg_o = 1'b1;
                cst_pos_o = CST_BYTE2;
                legal_o   = fn_zero;
            end
            default: begin
                len_o   = LEN_W'(1);
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ifd_fields.sv
// Extracts register identifiers and the little-endian constant from the window.
module ifd_fields
    import ifd_pkg::*;
#(
    parameter int NBYTES = WIN_B
)(
    input  logic [NBYTES*BYTE_W-1:0] win_i,
    input  logic                     has_reg_i,
    input  cst_pos_e                 cst_pos_i,
    output logic [NIB_W-1:0]         rsrc_o,
    output logic [NIB_W-1:0]         rdst_o,
    output logic [WORD_W-1:0]        imm_o
);

    localparam int REG_BYTE = 1;

    logic [BYTE_W-1:0] bytes [NBYTES];
    logic [WORD_W-1:0] cst_at1;
    logic [WORD_W-1:0] cst_at2;

    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_split
            assign bytes[b] = win_i[b*BYTE_W +: BYTE_W];
        end
        for (b = 0; b < CBYTES; b++) begin : g_cst
            assign cst_at1[b*BYTE_W +: BYTE_W] = bytes[b+1];
            assign cst_at2[b*BYTE_W +: BYTE_W] = bytes[b+2];
        end
    endgenerate

    always_comb begin
        if (has_reg_i) begin
            rsrc_o = bytes[REG_BYTE][BYTE_W-1:NIB_W];
            rdst_o = bytes[REG_BYTE][NIB_W-1:0];
        end else begin
            rsrc_o = REG_NONE;
            rdst_o = REG_NONE;
        end
        case (cst_pos_i)
            CST_BYTE1: imm_o = cst_at1;
            CST_BYTE2: imm_o = cst_at2;
            default:   imm_o = '0;
        endcase
    end

endmodule

// File: rtl/ifd_status.sv
// Status priority: bad address, then invalid, then halt, then normal.
module ifd_status
    import ifd_pkg::*;
(
    input  logic             fetch_ok_i,
    input  logic             legal_i,
    input  logic [NIB_W-1:0] opcode_i,
    output stat_e            status_o,
    output logic             fault_o
);

    always_comb begin
        if (!fetch_ok_i)               status_o = ST_ADR;
        else if (!legal_i)             status_o = ST_INS;
        else if (opcode_i == OP_HALT)  status_o = ST_HLT;
        else                           status_o = ST_AOK;
        fault_o = (status_o == ST_ADR) || (status_o == ST_INS);
    end

endmodule

// File: rtl/instr_fetch_decoder.sv
module instr_fetch_decoder
    import ifd_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic              fetch_ok_i,
    output logic [NIB_W-1:0]  opcode_o,
    output logic [NIB_W-1:0]  fncode_o,
    output logic [NIB_W-1:0]  rsrc_o,
    output logic [NIB_W-1:0]  rdst_o,
    output logic [WORD_W-1:0] imm_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [WORD_W-1:0] npc_o,
    output logic [2:0]        status_o
);

    logic [NIB_W-1:0]  op_w;
    logic [NIB_W-1:0]  fn_w;
    logic [LEN_W-1:0]  fmt_len;
    logic              fmt_has_reg;
    cst_pos_e          fmt_cst_pos;
    logic              fmt_legal;
    logic [NIB_W-1:0]  fld_rsrc;
    logic [NIB_W-1:0]  fld_rdst;
    logic [WORD_W-1:0] fld_imm;
    stat_e             st_w;
    logic              st_fault;

    dec_t dec_d;
    dec_t dec_q;
    dec_t dec_out;

    assign op_w = win_i[BYTE_W-1:NIB_W];
    assign fn_w = win_i[NIB_W-1:0];

    ifd_format u_format (
        .opcode_i  (op_w),
        .fncode_i  (fn_w),
        .len_o     (fmt_len),
        .has_reg_o (fmt_has_reg),
        .cst_pos_o (fmt_cst_pos),
        .legal_o   (fmt_legal)
    );

    ifd_fields #(.NBYTES(WIN_B)) u_fields (
        .win_i     (win_i),
        .has_reg_i (fmt_has_reg),
        .cst_pos_i (fmt_cst_pos),
        .rsrc_o    (fld_rsrc),
        .rdst_o    (fld_rdst),
        .imm_o     (fld_imm)
    );

    ifd_status u_status (
        .fetch_ok_i (fetch_ok_i),
        .legal_i    (fmt_legal),
        .opcode_i   (op_w),
        .status_o   (st_w),
        .fault_o    (st_fault)
    );

    always_comb begin
        dec_d        = DEC_RESET;
        dec_d.opcode = op_w;
        dec_d.fncode = fn_w;
        dec_d.status = st_w;
        if (st_fault) begin
            dec_d.rsrc = REG_NONE;
            dec_d.rdst = REG_NONE;
            dec_d.imm  = '0;
            dec_d.len  = '0;
            dec_d.npc  = pc_i;
        end else begin
            dec_d.rsrc = fld_rsrc;
            dec_d.rdst = fld_rdst;
            dec_d.imm  = fld_imm;
            dec_d.len  = fmt_len;
            dec_d.npc  = pc_i + WORD_W'(fmt_len);
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) dec_q <= DEC_RESET;
                else        dec_q <= dec_d;
            end
            assign dec_out = dec_q;
        end else begin : g_comb
            assign dec_q   = DEC_RESET;
            assign dec_out = dec_d;
        end
    endgenerate

    assign opcode_o = dec_out.opcode;
    assign fncode_o = dec_out.fncode;
    assign rsrc_o   = dec_out.rsrc;
    assign rdst_o   = dec_out.rdst;
    assign imm_o    = dec_out.imm;
    assign len_o    = dec_out.len;
    assign npc_o    = dec_out.npc;
    assign status_o = dec_out.status;

endmodule

// File: rtl/ifd_checker.sv
module ifd_checker
    import ifd_pkg::*;
#(
    parameter bit LAT = 1'b1
)(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] pc_i,
    input logic [WIN_W-1:0]  win_i,
    input logic              fetch_ok_i,
    input logic [NIB_W-1:0]  opcode_o,
    input logic [NIB_W-1:0]  fncode_o,
    input logic [NIB_W-1:0]  rsrc_o,
    input logic [NIB_W-1:0]  rdst_o,
    input logic [WORD_W-1:0] imm_o,
    input logic [LEN_W-1:0]  len_o,
    input logic [WORD_W-1:0] npc_o,
    input logic [2:0]        status_o
);

    logic [WORD_W-1:0] pc_s;
    logic [WIN_W-1:0]  win_s;
    logic              ok_s;
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    generate
        if (LAT) begin : g_dly
            logic [WORD_W-1:0] pc_r;
            logic [WIN_W-1:0]  win_r;
            logic              ok_r;
            always_ff @(posedge clk) begin
                pc_r  <= pc_i;
                win_r <= win_i;
                ok_r  <= fetch_ok_i;
            end
            assign pc_s  = pc_r;
            assign win_s = win_r;
            assign ok_s  = ok_r;
        end else begin : g_now
            assign pc_s  = pc_i;
            assign win_s = win_i;
            assign ok_s  = fetch_ok_i;
        end
    endgenerate

    // R1
    opcode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (opcode_o == win_s[7:4] && fncode_o == win_s[3:0]));

    // R8
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !ok_s) |-> (status_o == ST_ADR));

    // R6
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ok_s && win_s[7:0] == 8'h00) |-> (status_o == ST_HLT && len_o == 3'd1));

    // R2
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (status_o == ST_AOK || status_o == ST_HLT)) |->
        (len_o == 3'd1 || len_o == 3'd2 || len_o == 3'd5 || len_o == 3'd6));

    // R5
    next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (npc_o == pc_s + WORD_W'(len_o)));

    // R3
    no_reg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (len_o == 3'd1 || len_o == 3'd5)) |-> (rsrc_o == REG_NONE && rdst_o == REG_NONE));

    // R9
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (status_o == ST_ADR || status_o == ST_INS)) |->
        (len_o == 3'd0 && imm_o == '0 && rsrc_o == REG_NONE));

    // R7
    status_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (status_o >= 3'd1 && status_o <= 3'd4));

endmodule

bind instr_fetch_decoder ifd_checker #(.LAT(REG_OUT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc_i),
    .win_i      (win_i),
    .fetch_ok_i (fetch_ok_i),
    .opcode_o   (opcode_o),
    .fncode_o   (fncode_o),
    .rsrc_o     (rsrc_o),
    .rdst_o     (rdst_o),
    .imm_o      (imm_o),
    .len_o      (len_o),
    .npc_o      (npc_o),
    .status_o   (status_o)
);

// File: tb/instr_fetch_decoder_tb_top.sv
module instr_fetch_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [47:0] win_i = '0;
    logic        fetch_ok_i = 1'b1;
    logic [3:0]  opcode_o, fncode_o, rsrc_o, rdst_o;
    logic [31:0] imm_o, npc_o;
    logic [2:0]  len_o, status_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    instr_fetch_decoder #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .win_i(win_i), .fetch_ok_i(fetch_ok_i),
        .opcode_o(opcode_o), .fncode_o(fncode_o), .rsrc_o(rsrc_o), .rdst_o(rdst_o),
        .imm_o(imm_o), .len_o(len_o), .npc_o(npc_o), .status_o(status_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive on a falling edge, one rising edge of latency, sample on the next falling edge
    task automatic apply(logic [31:0] pc, logic [47:0] win, logic ok);
        @(negedge clk);
        pc_i = pc; win_i = win; fetch_ok_i = ok;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_all(string req, logic [3:0] op, logic [3:0] fn, logic [3:0] ra,
                              logic [3:0] rb, logic [31:0] imm, logic [2:0] len,
                              logic [31:0] npc, logic [2:0] st);
        chk(req, "opcode", {28'd0, opcode_o}, {28'd0, op});
        chk(req, "fncode", {28'd0, fncode_o}, {28'd0, fn});
        chk(req, "rsrc",   {28'd0, rsrc_o},   {28'd0, ra});
        chk(req, "rdst",   {28'd0, rdst_o},   {28'd0, rb});
        chk(req, "imm",    imm_o, imm);
        chk(req, "len",    {29'd0, len_o},    {29'd0, len});
        chk(req, "npc",    npc_o, npc);
        chk(req, "status", {29'd0, status_o}, {29'd0, st});
    endtask

    task automatic t_reset();
        // R10: values held during reset
        @(negedge clk);
        expect_all("R10", 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 3'd0, 32'h0, 3'd1);
    endtask

    task automatic t_six_byte();
        // R2 R3 R4 R1: bytes 30 82 cd ab 00 00
        apply(32'h0000_0100, 48'h0000_abcd_8230, 1'b1);
        expect_all("R4", 4'h3, 4'h0, 4'h8, 4'h2, 32'h0000_abcd, 3'd6, 32'h0000_0106, 3'd1);
        // bytes 50 15 f4 ff ff ff
        apply(32'h0000_0200, 48'hffff_fff4_1550, 1'b1);
        expect_all("R3", 4'h5, 4'h0, 4'h1, 4'h5, 32'hffff_fff4, 3'd6, 32'h0000_0206, 3'd1);
    endtask

    task automatic t_five_byte();
        // R4: call, bytes 80 28 00 00 00, trailing byte EE ignored
        apply(32'h0000_000c, 48'hee00_0000_2880, 1'b1);
        expect_all("R4", 4'h8, 4'h0, 4'hF, 4'hF, 32'h0000_0028, 3'd5, 32'h0000_0011, 3'd1);
        // R7 boundary: jump with function 6 is legal
        apply(32'h0000_0040, 48'h5512_3456_7876, 1'b1);
        expect_all("R2", 4'h7, 4'h6, 4'hF, 4'hF, 32'h1234_5678, 3'd5, 32'h0000_0045, 3'd1);
    endtask

    task automatic t_short();
        // R3 R2: ALU op 60 06, trailing junk ignored
        apply(32'h0000_0010, 48'hdead_beef_0660, 1'b1);
        expect_all("R3", 4'h6, 4'h0, 4'h0, 4'h6, 32'h0, 3'd2, 32'h0000_0012, 3'd1);
        // R2: return, one byte
        apply(32'h0000_0020, 48'h1122_3344_5590, 1'b1);
        expect_all("R2", 4'h9, 4'h0, 4'hF, 4'hF, 32'h0, 3'd1, 32'h0000_0021, 3'd1);
        // R6: all-zero window is halt
        apply(32'h0000_0011, 48'h0, 1'b1);
        expect_all("R6", 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 3'd1, 32'h0000_0012, 3'd2);
    endtask

    task automatic t_wrap();
        // R5: next address wraps modulo 2^32
        apply(32'hffff_fffe, 48'h0000_0001_f030, 1'b1);
        expect_all("R5", 4'h3, 4'h0, 4'hF, 4'h0, 32'h0000_0001, 3'd6, 32'h0000_0004, 3'd1);
    endtask

    task automatic t_invalid();
        // R7 R9: operation code above 0xB
        apply(32'h0000_0300, 48'h1111_1111_11c0, 1'b1);
        expect_all("R7", 4'hC, 4'h0, 4'hF, 4'hF, 32'h0, 3'd0, 32'h0000_0300, 3'd4);
        // R7: nop with nonzero function
        apply(32'h0000_0304, 48'h0, 1'b1);
        win_i = 48'h15;
        @(posedge clk); @(negedge clk);
        chk("R7", "nop fn status", {29'd0, status_o}, 32'd4);
        // R7: ALU function 4
        apply(32'h0000_0308, 48'h0000_0000_1264, 1'b1);
        expect_all("R9", 4'h6, 4'h4, 4'hF, 4'hF, 32'h0, 3'd0, 32'h0000_0308, 3'd4);
        // R7: jump function 7
        apply(32'h0000_030c, 48'h0000_0000_0077, 1'b1);
        chk("R7", "jump fn7 status", {29'd0, status_o}, 32'd4);
    endtask

    task automatic t_bad_addr();
        // R8: address fault beats halt and invalid
        apply(32'h0000_0400, 48'h0, 1'b0);
        expect_all("R8", 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 3'd0, 32'h0000_0400, 3'd3);
        apply(32'h0000_0404, 48'h0000_abcd_82f0, 1'b0);
        chk("R8", "fault over invalid", {29'd0, status_o}, 32'd3);
        // R10: recovery after a fault, one edge later
        apply(32'h0000_0408, 48'h0000_0000_00a0 | 48'h0000_0000_4f00, 1'b1);
        expect_all("R10", 4'hA, 4'h0, 4'h4, 4'hF, 32'h0, 3'd2, 32'h0000_040a, 3'd1);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_six_byte();
        t_five_byte();
        t_short();
        t_wrap();
        t_invalid();
        t_bad_addr();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule